// File: doc/BRIEF.md
# Nibble-Mask Pattern Word Codec

This block compresses and expands 32-bit words using a table of eight zero-nibble patterns. Each table entry is an 8-bit mask. Mask bit k covers nibble k, which is word bits 4k+3 down to 4k. When a mask bit is set, that nibble must be zero and is dropped. When it is clear, the nibble is kept.

On the compress path, a word is tested against every valid entry. The block returns a hit flag, the 3-bit index of the chosen entry, the kept nibbles packed toward the low end, and how many nibbles were kept. On the expand path, an index and a packed payload are turned back into the full word.

Entries 0 to 3 are fixed. Entries 4 to 7 start out empty and are filled at run time through a write-once port. Words that were compressed earlier therefore keep decoding the same way.

Top module: `nmc_codec`

## Requirements
- R1: After reset, the fixed entries 0 to 3 hold the masks 8'hFF, 8'hF0, 8'hFC and 8'hF8, and entries 4 to 7 are invalid. While in reset, all outputs are zero.
- R2: A word matches an entry only if the entry is valid and every nibble whose mask bit is 1 is zero.
- R3: If more than one entry matches, the entry with the most mask bits set is chosen. A tie goes to the lowest index.
- R4: On a hit, the payload holds the kept nibbles. The lowest kept nibble goes in payload bits 3:0, the next kept nibble in bits 7:4, and so on. Payload nibbles above the count are zero. The length equals the number of clear mask bits (0 to 8).
- R5: On a miss, the hit flag is 0, the index is 0, the payload is the whole word and the length is 8.
- R6: A write with `tbl_we_i` high and slot s on `tbl_slot_i` stores `tbl_mask_i` into entry 4+s and marks it valid. The compress and expand paths use the entry from the next cycle on.
- R7: A write to a dynamic entry that is already valid is ignored. The entry keeps its mask.
- R8: The expand path fills masked nibbles with zero. It fills the remaining nibbles from the payload, starting with the lowest payload nibble for the lowest kept position.
- R9: Expanding with the index of an invalid entry treats the mask as 8'h00, so the output word equals the payload.
- R10: Both paths are registered. Results for inputs sampled at one rising edge appear after that edge. A table write made at the same edge is not yet visible to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmp_word_i | input | 32 | Word to compress |
| cmp_hit_o | output | 1 | Word matched a valid entry |
| cmp_idx_o | output | 3 | Index of the chosen entry |
| cmp_payload_o | output | 32 | Packed kept nibbles |
| cmp_len_o | output | 4 | Number of payload nibbles |
| dec_idx_i | input | 3 | Entry index for expansion |
| dec_payload_i | input | 32 | Packed payload to expand |
| dec_word_o | output | 32 | Rebuilt word |
| tbl_we_i | input | 1 | Dynamic entry write strobe |
| tbl_slot_i | input | 2 | Dynamic slot (entry 4 + slot) |
| tbl_mask_i | input | 8 | Mask to store |

## Verification
Both results for a given input set are due exactly one rising edge after that set is sampled. The bench drives inputs on the falling edge and checks the outputs on the following falling edge, against a model that has already stepped forward by that one edge. The model's table applies a write only after it has computed the expected results for the same cycle. This way the check of a write made in the same cycle as a compress (R10) lands on the cycle where the old table still governs. Each later use of the written entry is checked on the cycle after the write.

// File: rtl/nmc_pkg.sv
package nmc_pkg;
    parameter int NIB_W    = 4;
    parameter int NIBBLES  = 8;
    parameter int WORD_W   = NIB_W * NIBBLES;
    parameter int ENTRIES  = 8;
    parameter int STATIC_N = 4;
    parameter int DYN_N    = ENTRIES - STATIC_N;
    parameter int IDX_W    = $clog2(ENTRIES);
    parameter int SLOT_W   = $clog2(DYN_N);
    parameter int LEN_W    = $clog2(NIBBLES + 1);

    typedef logic [NIBBLES-1:0] mask_t;
    typedef logic [WORD_W-1:0]  word_t;

    function automatic mask_t fixed_mask(input int i);
        case (i)
            0:       return 8'hFF;
            1:       return 8'hF0;
            2:       return 8'hFC;
            default: return 8'hF8;
        endcase
    endfunction

    function automatic mask_t nonzero_nibbles(input word_t w);
        mask_t m;
        for (int k = 0; k < NIBBLES; k++) m[k] = |w[k*NIB_W +: NIB_W];
        return m;
    endfunction
endpackage

// File: rtl/nmc_table.sv
module nmc_table
    import nmc_pkg::*;
(
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           we_i,
    input  logic [SLOT_W-1:0]              slot_i,
    input  mask_t                          mask_i,
    output logic [ENTRIES-1:0][NIBBLES-1:0] masks_o,
    output logic [ENTRIES-1:0]             valid_o
);
    typedef struct packed {
        logic [DYN_N-1:0][NIBBLES-1:0] mask;
        logic [DYN_N-1:0]              vld;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (we_i && !tbl_q.vld[slot_i]) begin
            tbl_d.mask[slot_i] = mask_i;
            tbl_d.vld[slot_i]  = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tbl_q <= '0;
        else         tbl_q <= tbl_d;
    end

    for (genvar i = 0; i < STATIC_N; i++) begin : g_fixed
        assign masks_o[i] = fixed_mask(i);
        assign valid_o[i] = 1'b1;
    end

    for (genvar j = 0; j < DYN_N; j++) begin : g_dyn
        assign masks_o[STATIC_N+j] = tbl_q.mask[j];
        assign valid_o[STATIC_N+j] = tbl_q.vld[j];

        // R7
        dyn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tbl_q.vld[j] |=> (tbl_q.vld[j] && $stable(tbl_q.mask[j])));
    end
endmodule

// File: rtl/nmc_compress.sv
module nmc_compress
    import nmc_pkg::*;
(
    input  word_t                          word_i,
    input  logic [ENTRIES-1:0][NIBBLES-1:0] masks_i,
    input  logic [ENTRIES-1:0]             valid_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               idx_o,
    output word_t                          payload_o,
    output logic [LEN_W-1:0]               len_o
);
    always_comb begin : pick
        mask_t nz;
        mask_t use_mask;
        int    best;
        int    cnt;
        int    pos;
        nz    = nonzero_nibbles(word_i);
        hit_o = 1'b0;
        idx_o = '0;
        best  = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            cnt = $countones(masks_i[i]);
            if (valid_i[i] && ((nz & masks_i[i]) == '0) && (!hit_o || cnt > best)) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
                best  = cnt;
            end
        end
        use_mask  = hit_o ? masks_i[idx_o] : '0;
        payload_o = '0;
        pos       = 0;
        for (int k = 0; k < NIBBLES; k++) begin
            if (!use_mask[k]) begin
                payload_o[pos*NIB_W +: NIB_W] = word_i[k*NIB_W +: NIB_W];
                pos = pos + 1;
            end
        end
        len_o = LEN_W'(pos);
    end
endmodule

// File: rtl/nmc_expand.sv
module nmc_expand
    import nmc_pkg::*;
(
    input  mask_t mask_i,
    input  word_t payload_i,
    output word_t word_o
);
    always_comb begin : unpack
        int pos;
        word_o = '0;
        pos    = 0;
        for (int k = 0; k < NIBBLES; k++) begin
            if (!mask_i[k]) begin
                word_o[k*NIB_W +: NIB_W] = payload_i[pos*NIB_W +: NIB_W];
                pos = pos + 1;
            end
        end
    end
endmodule

// File: rtl/nmc_codec.sv
module nmc_codec
    import nmc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [31:0]       cmp_word_i,
    output logic              cmp_hit_o,
    output logic [2:0]        cmp_idx_o,
    output logic [31:0]       cmp_payload_o,
    output logic [3:0]        cmp_len_o,
    input  logic [2:0]        dec_idx_i,
    input  logic [31:0]       dec_payload_i,
    output logic [31:0]       dec_word_o,
    input  logic              tbl_we_i,
    input  logic [1:0]        tbl_slot_i,
    input  logic [7:0]        tbl_mask_i
);
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        word_t            payload;
        logic [LEN_W-1:0] len;
        word_t            dword;
    } out_t;

    logic [ENTRIES-1:0][NIBBLES-1:0] tbl_masks;
    logic [ENTRIES-1:0]              tbl_valid;
    logic                            c_hit;
    logic [IDX_W-1:0]                c_idx;
    word_t                           c_payload;
    logic [LEN_W-1:0]                c_len;
    mask_t                           dec_mask;
    word_t                           d_word;
    out_t                            out_d, out_q;

    nmc_table u_table (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (tbl_we_i),
        .slot_i  (tbl_slot_i),
        .mask_i  (tbl_mask_i),
        .masks_o (tbl_masks),
        .valid_o (tbl_valid)
    );

    nmc_compress u_cmp (
        .word_i    (cmp_word_i),
        .masks_i   (tbl_masks),
        .valid_i   (tbl_valid),
        .hit_o     (c_hit),
        .idx_o     (c_idx),
        .payload_o (c_payload),
        .len_o     (c_len)
    );

    assign dec_mask = tbl_valid[dec_idx_i] ? tbl_masks[dec_idx_i] : '0;

    nmc_expand u_exp (
        .mask_i    (dec_mask),
        .payload_i (dec_payload_i),
        .word_o    (d_word)
    );

    always_comb begin
        out_d         = out_q;
        out_d.hit     = c_hit;
        out_d.idx     = c_idx;
        out_d.payload = c_payload;
        out_d.len     = c_len;
        out_d.dword   = d_word;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign cmp_hit_o     = out_q.hit;
    assign cmp_idx_o     = out_q.idx;
    assign cmp_payload_o = out_q.payload;
    assign cmp_len_o     = out_q.len;
    assign dec_word_o    = out_q.dword;

    // R2
    hit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_hit_o |-> (tbl_valid[cmp_idx_o] &&
                       ((nonzero_nibbles($past(cmp_word_i)) & tbl_masks[cmp_idx_o]) == '0)));

    // R5
    miss_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cmp_hit_o && $past(rst_ni)) |-> (cmp_len_o == LEN_W'(NIBBLES) &&
                                           cmp_payload_o == $past(cmp_word_i) &&
                                           cmp_idx_o == '0));

    // R4
    len_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_hit_o |-> (32'(cmp_len_o) + 32'($countones(tbl_masks[cmp_idx_o])) == 32'(NIBBLES)));
endmodule

// File: tb/tb_nmc_codec.sv
module tb_nmc_codec;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cmp_word;
    logic        cmp_hit;
    logic [2:0]  cmp_idx;
    logic [31:0] cmp_payload;
    logic [3:0]  cmp_len;
    logic [2:0]  dec_idx;
    logic [31:0] dec_payload;
    logic [31:0] dec_word;
    logic        tbl_we;
    logic [1:0]  tbl_slot;
    logic [7:0]  tbl_mask;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    nmc_codec dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cmp_word_i(cmp_word), .cmp_hit_o(cmp_hit), .cmp_idx_o(cmp_idx),
        .cmp_payload_o(cmp_payload), .cmp_len_o(cmp_len),
        .dec_idx_i(dec_idx), .dec_payload_i(dec_payload), .dec_word_o(dec_word),
        .tbl_we_i(tbl_we), .tbl_slot_i(tbl_slot), .tbl_mask_i(tbl_mask)
    );

    // reference table
    logic [7:0] m_mask [8];
    bit         m_vld  [8];

    // expectations for the cycle in flight
    bit          pend;
    bit          e_hit;
    int          e_idx;
    logic [31:0] e_pay;
    int          e_len;
    logic [31:0] e_dec;
    bit          e_dinv;
    string       e_note;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit nib_zero(logic [31:0] w, int k);
        return ((w >> (4*k)) & 32'hF) == 0;
    endfunction

    task automatic model_reset();
        m_mask[0] = 8'hFF; m_mask[1] = 8'hF0; m_mask[2] = 8'hFC; m_mask[3] = 8'hF8;
        for (int i = 0; i < 8; i++) m_vld[i] = (i < 4);
        for (int i = 4; i < 8; i++) m_mask[i] = 8'h00;
    endtask

    task automatic predict(logic [31:0] w, logic [2:0] di, logic [31:0] dp);
        int best = -1;
        logic [7:0] um;
        int p;
        e_hit = 0; e_idx = 0;
        for (int i = 0; i < 8; i++) begin
            bit ok = m_vld[i];
            int c = 0;
            for (int k = 0; k < 8; k++) if (m_mask[i][k]) begin
                c++;
                if (!nib_zero(w, k)) ok = 0;
            end
            if (ok && c > best) begin best = c; e_hit = 1; e_idx = i; end
        end
        um = e_hit ? m_mask[e_idx] : 8'h00;
        e_pay = 0; p = 0;
        for (int k = 0; k < 8; k++) if (!um[k]) begin
            e_pay = e_pay | (((w >> (4*k)) & 32'hF) << (4*p));
            p++;
        end
        e_len = p;
        e_dinv = !m_vld[di];
        um = m_vld[di] ? m_mask[di] : 8'h00;
        e_dec = 0; p = 0;
        for (int k = 0; k < 8; k++) if (!um[k]) begin
            e_dec = e_dec | (((dp >> (4*p)) & 32'hF) << (4*k));
            p++;
        end
    endtask

    task automatic compare();
        string t_hit, t_idx, t_pay, t_dec;
        t_hit = "R2";
        t_idx = e_hit ? (e_idx >= 4 ? "R6" : "R3") : "R5";
        t_pay = e_hit ? "R4" : "R5";
        t_dec = e_dinv ? "R9" : "R8";
        if (e_note != "") begin t_hit = e_note; t_idx = e_note; t_pay = e_note; t_dec = e_note; end
        check(t_hit, "hit", 32'(cmp_hit), 32'(e_hit));
        check(t_idx, "idx", 32'(cmp_idx), 32'(e_idx));
        check(t_pay, "payload", cmp_payload, e_pay);
        check(t_pay, "len", 32'(cmp_len), 32'(e_len));
        check(t_dec, "dec_word", dec_word, e_dec);
    endtask

    // One cycle: check the results of the previous inputs (R10: due one edge
    // later), then drive new inputs and advance the model.
    task automatic step(logic [31:0] w, bit we, logic [1:0] s, logic [7:0] m,
                        logic [2:0] di, logic [31:0] dp, string note);
        @(negedge clk);
        if (pend) compare();
        predict(w, di, dp);
        e_note = note;
        if (we && !m_vld[4+s]) begin m_vld[4+s] = 1; m_mask[4+s] = m; end
        cmp_word = w; tbl_we = we; tbl_slot = s; tbl_mask = m;
        dec_idx = di; dec_payload = dp;
        pend = 1;
    endtask

    task automatic cw(logic [31:0] w, string note);
        step(w, 0, 2'd0, 8'h00, 3'd0, 32'h0, note);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pend = 0; e_note = "";
        rst_n = 0; cmp_word = 0; tbl_we = 0; tbl_slot = 0; tbl_mask = 0;
        dec_idx = 0; dec_payload = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs held at zero while in reset
        check("R1", "hit", 32'(cmp_hit), 0);
        check("R1", "len", 32'(cmp_len), 0);
        check("R1", "payload", cmp_payload, 0);
        check("R1", "dec_word", dec_word, 0);
        rst_n = 1;
        // R1: fixed entries exercised directly
        cw(32'h0000_0000, "R1");
        cw(32'h0000_00AB, "R1");
        cw(32'h0000_1234, "R1");
        cw(32'h0000_0ABC, "R1");
        step(32'h1234_0000, 0, 2'd0, 8'h00, 3'd4, 32'h0000_5678, "R1");
        cw(32'h1000_0000, "");
        cw(32'h0000_F00F, "");
        // R10: write and compress in the same cycle, old table governs
        step(32'h1234_0000, 1, 2'd0, 8'h0F, 3'd0, 32'h0, "R10");
        cw(32'h1234_0000, "R6");
        // R7: rewrite of a valid slot has no effect
        step(32'h1234_0000, 1, 2'd0, 8'h3F, 3'd0, 32'h0, "R7");
        step(32'h1234_0000, 0, 2'd0, 8'h00, 3'd4, 32'h0000_4321, "R7");
        step(32'h0000_0000, 0, 2'd0, 8'h00, 3'd5, 32'hDEAD_BEEF, "R9");
        step(32'h0, 1, 2'd1, 8'h55, 3'd0, 32'h0, "");
        step(32'hA0B0_C0D0, 0, 2'd0, 8'h00, 3'd5, 32'h0000_ABCD, "R6");
        step(32'h0, 1, 2'd2, 8'hF0, 3'd0, 32'h0, "");
        cw(32'h0000_5678, "R3");
        step(32'h0, 1, 2'd3, 8'hFE, 3'd0, 32'h0, "");
        step(32'h0000_0007, 0, 2'd0, 8'h00, 3'd7, 32'h0000_0009, "R3");
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w = $urandom;
            logic [7:0]  keep = 8'($urandom);
            logic [31:0] msk = 0;
            for (int k = 0; k < 8; k++) if (keep[k] && ($urandom % 3 == 0)) msk |= 32'hF << (4*k);
            step(w & msk, ($urandom % 50) == 0, 2'($urandom), 8'($urandom),
                 3'($urandom), $urandom, "");
        end
        @(negedge clk);
        if (pend) compare();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule